// File: doc/BRIEF.md
# Frame Size Statistics Counters

This block holds a bank of 32-bit statistics counters for one traffic direction of a network port. Each time the datapath signals that a frame has completed, the block takes the frame's byte length. It then bumps a packet count and a good-frame count, adds the length to a total-octet sum and a good-octet sum, and increments exactly one size-range bin. The bins are: fragments (under 64 bytes), exactly 64, 65..127, 128..255, 256..511, 512..1023, 1024..2047, and 2048 or more.

Software sees the counters through a word-indexed window. It can read any counter at any time, and it can overwrite any counter, for example to preset or clear it. The word index of each counter is fixed: packets 0, good frames 1, total octets 2, good octets 3, and the eight size bins at 4 through 11 in ascending size order. Indices 12 and above are unused.

The control is a two-state machine. ST_IDLE means no frame is pending. ST_APPLY is the cycle in which a captured length is added into the bank. On a frame-done pulse, ST_IDLE goes to ST_APPLY and the length is captured. While another pulse arrives, ST_APPLY stays in ST_APPLY, so back-to-back frames are each applied. Without a pulse, ST_APPLY returns to ST_IDLE.

Top module: `frame_size_stats`

## Requirements
- R1: While reset is held, every counter is cleared to zero, and a read of every index afterwards returns zero.
- R2: Each completed frame adds 1 to the packet counter (index 0) and to the good-frame counter (index 1).
- R3: Each completed frame adds its length to the total-octet counter (index 2) and to the good-octet counter (index 3).
- R4: Each frame increments exactly one bin, chosen by its length: below 64 goes to index 4; exactly 64 to index 5; 65..127 to 6; 128..255 to 7; 256..511 to 8; 512..1023 to 9; 1024..2047 to 10; 2048 or more to 11.
- R5: A frame-done pulse sampled at one rising edge updates the counters at the following rising edge. A pulse held on consecutive cycles counts one frame per cycle. With no frame and no write, the counters hold their values.
- R6: A software write to index 0..11 replaces that counter at the next rising edge. The read data port shows the indexed counter combinationally.
- R7: When a software write and a frame update hit the same counter in one cycle, the result is the written value plus the frame's increment.
- R8: All counters wrap modulo 2^32 and never saturate.
- R9: Reads of indices 12..15 return zero, and writes to them change no counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_done | input | 1 | One-cycle pulse per completed frame |
| frame_len | input | LEN_W (16) | Byte length of the completed frame |
| sw_we | input | 1 | Software write strobe |
| sw_widx | input | IDX_W (4) | Word index of the counter to write |
| sw_wdata | input | CNT_W (32) | Value to write |
| sw_ridx | input | IDX_W (4) | Word index of the counter to read |
| sw_rdata | output | CNT_W (32) | Value of the indexed counter, zero for unused indices |

## Verification
A software write and a frame update can land on the same counter in the same cycle. The bench provokes this by asserting the write one cycle after a frame-done pulse, first on the packet counter and then on the total-octet counter, so that the write lands in the update cycle. It judges the outcome by reading back the written value plus exactly the frame's increment (1, or the frame length) while every other counter follows the normal per-frame rule. A checker also compares the packet counter against the registered write value plus one whenever the two coincide.

// File: rtl/fss_pkg.sv
package fss_pkg;
    localparam int NUM_BINS = 8;
    localparam int NUM_CNT  = 4 + NUM_BINS;

    localparam int IX_PKT   = 0;
    localparam int IX_GOOD  = 1;
    localparam int IX_OCT   = 2;
    localparam int IX_GOCT  = 3;
    localparam int IX_BIN0  = 4;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_APPLY = 1'b1
    } fss_state_e;
endpackage

// File: rtl/fss_bin_sel.sv
module fss_bin_sel #(
    parameter int LEN_W = 16
) (
    input  logic [LEN_W-1:0]          len,
    output logic [fss_pkg::NUM_BINS-1:0] hit
);
    localparam int BW = fss_pkg::NUM_BINS;

    // Upper bound (exclusive) of bins 2..6 is 2^(k+5); bin 0 is <64, bin 1 is ==64.
    logic [BW-1:0] below;

    generate
        for (genvar k = 0; k < BW; k++) begin : g_lim
            if (k == 0) begin : g_frag
                assign below[k] = (32'(len) < 32'd64);
            end else if (k == 1) begin : g_64
                assign below[k] = (32'(len) < 32'd65);
            end else if (k == BW - 1) begin : g_top
                assign below[k] = 1'b1;
            end else begin : g_mid
                assign below[k] = (32'(len) < (32'd1 << (k + 5)));
            end
        end
    endgenerate

    always_comb begin
        hit = '0;
        for (int k = 0; k < BW; k++) begin
            if (below[k] && (k == 0 || !below[k-1])) begin
                hit[k] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/fss_counter.sv
module fss_counter #(
    parameter int CNT_W = 32,
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CNT_W-1:0] wdata,
    input  logic             inc,
    input  logic [LEN_W-1:0] amt,
    output logic [CNT_W-1:0] q
);
    logic [CNT_W-1:0] base;
    logic [CNT_W-1:0] step;

    always_comb begin
        base = wr ? wdata : q;
        step = inc ? {{(CNT_W-LEN_W){1'b0}}, amt} : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= base + step;
        end
    end
endmodule

// File: rtl/frame_size_stats.sv
module frame_size_stats #(
    parameter int LEN_W = 16,
    parameter int CNT_W = 32,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_done,
    input  logic [LEN_W-1:0] frame_len,
    input  logic             sw_we,
    input  logic [IDX_W-1:0] sw_widx,
    input  logic [CNT_W-1:0] sw_wdata,
    input  logic [IDX_W-1:0] sw_ridx,
    output logic [CNT_W-1:0] sw_rdata
);
    import fss_pkg::*;

    localparam int NC = NUM_CNT;

    fss_state_e state_q, state_d;
    logic [LEN_W-1:0]     len_q;
    logic                 apply_en;
    logic [NUM_BINS-1:0]  bin_hit;
    logic [CNT_W-1:0]     cnt_q [NC];
    logic [NC*CNT_W-1:0]  cnt_flat;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (frame_done) state_d = ST_APPLY;
            ST_APPLY: if (!frame_done) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Length capture alongside the state transition
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q <= '0;
        end else if (frame_done) begin
            len_q <= frame_len;
        end
    end

    // Outputs of the state machine
    always_comb begin
        apply_en = 1'b0;
        unique case (state_q)
            ST_IDLE:  apply_en = 1'b0;
            ST_APPLY: apply_en = 1'b1;
            default:  apply_en = 1'b0;
        endcase
    end

    fss_bin_sel #(.LEN_W(LEN_W)) u_bin (
        .len (len_q),
        .hit (bin_hit)
    );

    generate
        for (genvar i = 0; i < NC; i++) begin : g_cnt
            logic             inc_i;
            logic [LEN_W-1:0] amt_i;
            logic             wr_i;

            assign wr_i = sw_we && (sw_widx == IDX_W'(i));

            if (i == IX_OCT || i == IX_GOCT) begin : g_octets
                assign inc_i = apply_en;
                assign amt_i = len_q;
            end else if (i < IX_BIN0) begin : g_frames
                assign inc_i = apply_en;
                assign amt_i = LEN_W'(1);
            end else begin : g_bins
                assign inc_i = apply_en && bin_hit[i-IX_BIN0];
                assign amt_i = LEN_W'(1);
            end

            fss_counter #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_c (
                .clk   (clk),
                .rst_n (rst_n),
                .wr    (wr_i),
                .wdata (sw_wdata),
                .inc   (inc_i),
                .amt   (amt_i),
                .q     (cnt_q[i])
            );

            assign cnt_flat[i*CNT_W +: CNT_W] = cnt_q[i];
        end
    endgenerate

    always_comb begin
        sw_rdata = '0;
        for (int i = 0; i < NC; i++) begin
            if (sw_ridx == IDX_W'(i)) begin
                sw_rdata = cnt_q[i];
            end
        end
    end
endmodule

// File: rtl/frame_size_stats_chk.sv
module frame_size_stats_chk #(
    parameter int LEN_W = 16,
    parameter int CNT_W = 32,
    parameter int IDX_W = 4
) (
    input logic                                 clk,
    input logic                                 rst_n,
    input logic                                 apply,
    input logic [fss_pkg::NUM_BINS-1:0]         bin_hit,
    input logic [LEN_W-1:0]                     len_q,
    input logic [fss_pkg::NUM_CNT*CNT_W-1:0]    cnt_flat,
    input logic                                 sw_we,
    input logic [IDX_W-1:0]                     sw_widx,
    input logic [CNT_W-1:0]                     sw_wdata,
    input logic [IDX_W-1:0]                     sw_ridx,
    input logic [CNT_W-1:0]                     sw_rdata
);
    logic [CNT_W-1:0] pkt;
    logic [CNT_W-1:0] oct;
    logic             wr_pkt;
    logic             wr_oct;

    assign pkt    = cnt_flat[CNT_W-1:0];
    assign oct    = cnt_flat[3*CNT_W-1:2*CNT_W];
    assign wr_pkt = sw_we && (sw_widx == IDX_W'(0));
    assign wr_oct = sw_we && (sw_widx == IDX_W'(2));

    p_pkt_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (apply && !wr_pkt) |=> (pkt == $past(pkt) + 1'b1));

    p_octet_add_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (apply && !wr_oct) |=> (oct == $past(oct) + {{(CNT_W-LEN_W){1'b0}}, $past(len_q)}));

    p_one_bin_r4: assert property (@(posedge clk) disable iff (!rst_n)
        apply |-> ($countones(bin_hit) == 1));

    p_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!apply && !sw_we) |=> $stable(cnt_flat));

    p_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pkt && !apply) |=> (pkt == $past(sw_wdata)));

    p_merge_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pkt && apply) |=> (pkt == $past(sw_wdata) + 1'b1));

    p_unused_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_ridx >= IDX_W'(fss_pkg::NUM_CNT)) |-> (sw_rdata == '0));
endmodule

bind frame_size_stats frame_size_stats_chk #(
    .LEN_W (LEN_W),
    .CNT_W (CNT_W),
    .IDX_W (IDX_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .apply    (apply_en),
    .bin_hit  (bin_hit),
    .len_q    (len_q),
    .cnt_flat (cnt_flat),
    .sw_we    (sw_we),
    .sw_widx  (sw_widx),
    .sw_wdata (sw_wdata),
    .sw_ridx  (sw_ridx),
    .sw_rdata (sw_rdata)
);

// File: tb/frame_size_stats_test.sv
`timescale 1ns/1ps
module frame_size_stats_test;
    localparam int LEN_W = 16;
    localparam int CNT_W = 32;
    localparam int IDX_W = 4;
    localparam int NUM   = 12;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             frame_done = 1'b0;
    logic [LEN_W-1:0] frame_len = '0;
    logic             sw_we = 1'b0;
    logic [IDX_W-1:0] sw_widx = '0;
    logic [CNT_W-1:0] sw_wdata = '0;
    logic [IDX_W-1:0] sw_ridx = '0;
    logic [CNT_W-1:0] sw_rdata;

    int checks = 0;
    int errors = 0;
    logic [CNT_W-1:0] exp_c [NUM];

    always #4 clk = ~clk;

    frame_size_stats #(.LEN_W(LEN_W), .CNT_W(CNT_W), .IDX_W(IDX_W)) uut (
        .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .frame_len(frame_len),
        .sw_we(sw_we), .sw_widx(sw_widx), .sw_wdata(sw_wdata),
        .sw_ridx(sw_ridx), .sw_rdata(sw_rdata)
    );

    function automatic int bin_of(int len);
        if (len < 64)   return 4;
        if (len == 64)  return 5;
        if (len < 128)  return 6;
        if (len < 256)  return 7;
        if (len < 512)  return 8;
        if (len < 1024) return 9;
        if (len < 2048) return 10;
        return 11;
    endfunction

    task automatic model(int len);
        exp_c[0] = exp_c[0] + 1;
        exp_c[1] = exp_c[1] + 1;
        exp_c[2] = exp_c[2] + CNT_W'(len);
        exp_c[3] = exp_c[3] + CNT_W'(len);
        exp_c[bin_of(len)] = exp_c[bin_of(len)] + 1;
    endtask

    task automatic chk(int idx, logic [CNT_W-1:0] e, string tag);
        sw_ridx = IDX_W'(idx);
        #1;
        checks++;
        if (sw_rdata !== e) begin
            errors++;
            $display("FAIL %s idx %0d actual %h expected %h", tag, idx, sw_rdata, e);
        end
    endtask

    task automatic chk_all(string tag);
        for (int i = 0; i < NUM; i++) chk(i, exp_c[i], tag);
    endtask

    task automatic send1(int len);
        @(negedge clk); frame_done = 1'b1; frame_len = LEN_W'(len);
        @(negedge clk); frame_done = 1'b0;
        @(negedge clk);
        model(len);
    endtask

    task automatic wr(int idx, logic [CNT_W-1:0] val);
        @(negedge clk); sw_we = 1'b1; sw_widx = IDX_W'(idx); sw_wdata = val;
        @(negedge clk); sw_we = 1'b0;
        if (idx < NUM) exp_c[idx] = val;
    endtask

    // Frame in one cycle, write to the same counter in its update cycle
    task automatic collide(int idx, int len, logic [CNT_W-1:0] val);
        @(negedge clk); frame_done = 1'b1; frame_len = LEN_W'(len);
        @(negedge clk); frame_done = 1'b0;
        sw_we = 1'b1; sw_widx = IDX_W'(idx); sw_wdata = val;
        @(negedge clk); sw_we = 1'b0;
        model(len);
        exp_c[idx] = val + ((idx == 2 || idx == 3) ? CNT_W'(len) : 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete, actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int boundary [15] = '{0, 63, 64, 65, 127, 128, 255, 256, 511, 512,
                              1023, 1024, 2047, 2048, 65535};
        for (int i = 0; i < NUM; i++) exp_c[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_all("R1 reset");

        // R4 bin boundaries, one frame at a time; R2/R3 totals follow
        foreach (boundary[k]) begin
            send1(boundary[k]);
            chk(bin_of(boundary[k]), exp_c[bin_of(boundary[k])], "R4 bin");
        end
        chk(0, exp_c[0], "R2 packets");
        chk(1, exp_c[1], "R2 good frames");
        chk(2, exp_c[2], "R3 octets");
        chk(3, exp_c[3], "R3 good octets");

        // R5 sweep of every length 0..2100 back to back
        for (int l = 0; l <= 2100; l++) begin
            @(negedge clk); frame_done = 1'b1; frame_len = LEN_W'(l);
            model(l);
        end
        @(negedge clk); frame_done = 1'b0;
        @(negedge clk);
        chk_all("R5 back-to-back sweep");
        repeat (5) @(negedge clk);
        chk_all("R5 idle hold");

        // R6 plain software write
        wr(5, 32'h0000_1234);
        chk(5, 32'h0000_1234, "R6 write");
        wr(11, 32'hA5A5_0000);
        chk_all("R6 write others untouched");

        // R7 write and update in the same cycle
        collide(0, 100, 32'h0000_0500);
        chk_all("R7 merge packets");
        collide(2, 300, 32'h0000_7000);
        chk_all("R7 merge octets");

        // R8 wrap
        wr(2, 32'hFFFF_FFF0);
        wr(0, 32'hFFFF_FFFF);
        send1(32);
        chk(2, 32'h0000_0010, "R8 octet wrap");
        chk(0, 32'h0000_0000, "R8 packet wrap");

        // R9 unused indices
        wr(13, 32'h0000_DEAD);
        chk(13, 32'h0, "R9 unused read");
        chk(15, 32'h0, "R9 unused read");
        chk_all("R9 unused write no effect");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule